// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns a system clock into the bit grid of a CAN node. A prescaler divides the clock into time quanta. Each nominal bit is built from a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment, and every length comes from a configuration input. The bus is sampled at the end of the first phase segment. The sampled value is handed to the protocol logic together with a one-cycle sample strobe. A transmit-point strobe marks the start of every bit.

The receive line passes through a two-flop synchronizer. Each recessive-to-dominant transition on it is then used to keep the bit grid aligned with the other nodes. While the frame logic holds the hard-sync enable, which it does while waiting for a start of frame, such an edge restarts the bit at once. At other times the edge moves the sample point by the measured phase error, never by more than the jump width. It lengthens the first phase segment if it arrives late and shortens the second if it arrives early. These resynchronizations are skipped while the node itself drives a dominant level. Only one synchronization is taken in each interval between two sample points.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is active, and on the first clock after it is released, `sample_stb` and `tx_stb` are 0 and `rx_bit` is 1 (recessive). Dominant is 0 on `rx_raw` and `rx_bit`.
- R2: A time quantum lasts `cfg_brp`+1 clocks. With no synchronization, a bit lasts 1+`cfg_prop`+`cfg_ph1`+`cfg_ph2` quanta. `tx_stb` is a one-clock pulse in the first clock of each bit's sync quantum, and at most one such pulse occurs between two sample strobes.
- R3: `sample_stb` is a one-clock pulse in the clock after the quantum that ends the first phase segment. With no synchronization, this is 1+`cfg_prop`+`cfg_ph1` quanta after the bit started. It never coincides with `tx_stb`.
- R4: `rx_bit` takes the value of `rx_raw` after the two-flop synchronizer at the sample point and holds it until the next `sample_stb`.
- R5: While `hsync_en` is 1, a 1-to-0 transition of the synchronized receive line restarts the bit. The new sync quantum begins at the third rising clock edge after `rx_raw` falls, and no strobe is produced at that edge. A 0-to-1 transition never synchronizes.
- R6: With `hsync_en` and `tx_dom` both 0, a falling edge in quantum q of the bit, where 1 ≤ q ≤ the sample quantum, lengthens the first phase segment by min(q, `cfg_sjw`) quanta.
- R7: Under the same conditions, a falling edge in quantum q after the sample point shortens the second phase segment by min(e, `cfg_sjw`) quanta. Here e is the last quantum index of the bit plus 1, minus q. If the shortened bit's end falls on or before q, the bit ends with quantum q.
- R8: While `tx_dom` is 1, falling edges cause no resynchronization.
- R9: Between two sample strobes at most one synchronization takes effect, and a hard synchronization counts as that one. A second falling edge before the next sample point leaves the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Asynchronous receive line, 0 is dominant |
| tx_dom | input | 1 | Node is currently driving a dominant bit |
| hsync_en | input | 1 | Hard synchronization allowed (waiting for start of frame) |
| cfg_brp | input | BRP_W | Prescaler; one quantum is cfg_brp+1 clocks |
| cfg_prop | input | SEG_W | Propagation segment length in quanta |
| cfg_ph1 | input | SEG_W | First phase segment length in quanta |
| cfg_ph2 | input | SEG_W | Second phase segment length in quanta |
| cfg_sjw | input | SJW_W | Synchronization jump width in quanta |
| sample_stb | output | 1 | One-clock pulse when a bit has been sampled |
| rx_bit | output | 1 | Most recently sampled bus value |
| tx_stb | output | 1 | One-clock pulse at the start of each bit |

## Verification
The assertions take the segment settings to be non-zero and the second phase segment to be at least the jump width. They also take it that the configuration does not shrink a bit below the quantum already reached since the last bit start. The stimulus changes the jump width only in bits with no pending edge. It changes the other settings once, mid-bit and early in a quantum count, while no comparison is armed, and then realigns the grid with a hard synchronization. Receive-line changes are applied on falling clock edges and held for several quanta, so each edge falls into a known quantum of a known bit.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 4,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_raw,
  input  logic             tx_dom,
  input  logic             hsync_en,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  output logic             sample_stb,
  output logic             rx_bit,
  output logic             tx_stb
);
  localparam int QW = (SJW_W > SEG_W) ? SJW_W + 3 : SEG_W + 2;

  logic             rx_meta, rx_s, rx_d;
  logic [BRP_W-1:0] pcnt;
  logic [QW-1:0]    qcnt, ext, shr;
  logic             edge_pend, sync_done;

  logic             fall, tick, hard, can_rs, lengthen, shorten, at_sample, at_end;
  logic [QW-1:0]    sjw_q, sp_pos, end_pos, err_early, lim_late, lim_early, sp_nxt, end_nxt;

  assign fall   = rx_d & ~rx_s;
  assign tick   = (pcnt >= cfg_brp);
  assign hard   = fall & hsync_en;
  assign can_rs = tick & (edge_pend | fall) & ~hsync_en & ~tx_dom & ~sync_done;

  assign sjw_q     = QW'(cfg_sjw);
  assign sp_pos    = QW'(cfg_prop) + QW'(cfg_ph1) + ext;
  assign end_pos   = sp_pos + QW'(cfg_ph2) - shr;
  assign err_early = end_pos + QW'(1) - qcnt;

  assign lengthen  = can_rs && (qcnt != '0) && (qcnt <= sp_pos);
  assign shorten   = can_rs && (qcnt > sp_pos);
  assign lim_late  = (qcnt < sjw_q) ? qcnt : sjw_q;
  assign lim_early = (err_early < sjw_q) ? err_early : sjw_q;

  assign sp_nxt    = lengthen ? sp_pos + lim_late : sp_pos;
  assign end_nxt   = shorten ? end_pos - lim_early : end_pos;
  assign at_sample = tick && (qcnt == sp_nxt);
  assign at_end    = tick && (qcnt >= end_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta    <= 1'b1;
      rx_s       <= 1'b1;
      rx_d       <= 1'b1;
      pcnt       <= '0;
      qcnt       <= '0;
      ext        <= '0;
      shr        <= '0;
      edge_pend  <= 1'b0;
      sync_done  <= 1'b0;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      rx_bit     <= 1'b1;
    end else begin
      rx_meta    <= rx_raw;
      rx_s       <= rx_meta;
      rx_d       <= rx_s;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      if (hard) begin
        pcnt      <= '0;
        qcnt      <= '0;
        ext       <= '0;
        shr       <= '0;
        edge_pend <= 1'b0;
        sync_done <= 1'b1;
      end else begin
        pcnt      <= tick ? '0 : pcnt + 1'b1;
        edge_pend <= tick ? 1'b0 : (edge_pend | fall);
        if (tick) begin
          if (lengthen) ext <= ext + lim_late;
          if (shorten)  shr <= shr + lim_early;
          if (lengthen || shorten) sync_done <= 1'b1;
          if (at_sample) begin
            sample_stb <= 1'b1;
            rx_bit     <= rx_s;
            sync_done  <= 1'b0;
          end
          if (at_end) begin
            qcnt   <= '0;
            ext    <= '0;
            shr    <= '0;
            tx_stb <= 1'b1;
          end else begin
            qcnt <= qcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_stb,
  input logic tx_stb,
  input logic rx_bit
);
  logic start_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          start_seen <= 1'b0;
    else if (sample_stb) start_seen <= 1'b0;
    else if (tx_stb)     start_seen <= 1'b1;
  end

  assert_strobe_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  assert_sample_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  assert_bit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(rx_bit));

  assert_one_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> !start_seen);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .tx_stb     (tx_stb),
  .rx_bit     (rx_bit)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n, rx_raw, tx_dom, hsync_en;
  logic [5:0] cfg_brp;
  logic [3:0] cfg_prop, cfg_ph1, cfg_ph2;
  logic [1:0] cfg_sjw;
  logic       sample_stb, rx_bit, tx_stb;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  armed = 1'b0;
  bit  done = 1'b0;
  int  s0, s1;

  typedef struct {
    bit    is_tx;
    int    at;
    bit    val;
    string req;
  } exp_t;
  exp_t sbq[$];
  exp_t it;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .tx_dom(tx_dom), .hsync_en(hsync_en),
    .cfg_brp(cfg_brp), .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2),
    .cfg_sjw(cfg_sjw), .sample_stb(sample_stb), .rx_bit(rx_bit), .tx_stb(tx_stb)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(bit is_tx, int at, bit val, string req);
    exp_t e;
    e.is_tx = is_tx; e.at = at; e.val = val; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (armed && (sample_stb || tx_stb)) begin
      if (sbq.size() == 0) begin
        chk("R3", "unexpected strobe cycle", cyc, -1);
      end else begin
        it = sbq.pop_front();
        chk(it.req, it.is_tx ? "tx point kind" : "sample kind", int'(tx_stb), int'(it.is_tx));
        chk(it.req, "strobe cycle", cyc, it.at);
        if (!it.is_tx) chk(it.req, "sampled bit", int'(rx_bit), int'(it.val));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2: watchdog expired actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_raw = 1'b1; tx_dom = 1'b0; hsync_en = 1'b0;
    cfg_brp = 6'd1; cfg_prop = 4'd2; cfg_ph1 = 4'd3; cfg_ph2 = 4'd3; cfg_sjw = 2'd2;
    repeat (4) @(negedge clk);
    chk("R1", "sample_stb in reset", int'(sample_stb), 0);
    chk("R1", "tx_stb in reset", int'(tx_stb), 0);
    chk("R1", "rx_bit in reset", int'(rx_bit), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sample_stb after release", int'(sample_stb), 0);
    chk("R1", "tx_stb after release", int'(tx_stb), 0);
    chk("R1", "rx_bit after release", int'(rx_bit), 1);

    // quantum 2 clocks, bit 9 quanta, sample at end of quantum 5
    hsync_en = 1'b1;
    wait_cyc(20);
    s0 = cyc + 3;
    push(0, s0 + 12,  0, "R5");
    push(1, s0 + 18,  0, "R2");
    push(0, s0 + 30,  1, "R4");
    push(1, s0 + 36,  0, "R2");
    push(0, s0 + 52,  0, "R6");
    push(1, s0 + 58,  0, "R6");
    push(0, s0 + 70,  1, "R4");
    push(1, s0 + 74,  0, "R7");
    push(0, s0 + 86,  0, "R7");
    push(1, s0 + 92,  0, "R2");
    push(0, s0 + 104, 1, "R4");
    push(1, s0 + 108, 0, "R7");
    push(0, s0 + 120, 0, "R3");
    push(1, s0 + 126, 0, "R2");
    push(0, s0 + 138, 0, "R8");
    push(1, s0 + 144, 0, "R8");
    push(0, s0 + 156, 0, "R3");
    push(1, s0 + 162, 0, "R2");
    push(0, s0 + 178, 0, "R9");
    push(1, s0 + 184, 0, "R9");
    rx_raw = 1'b0;
    wait_cyc(s0);
    hsync_en = 1'b0;
    armed = 1'b1;
    wait_cyc(s0 + 14);  rx_raw = 1'b1;             // rising edge: no sync
    wait_cyc(s0 + 40);  rx_raw = 1'b0;             // R6: quantum 3, +2
    wait_cyc(s0 + 60);  rx_raw = 1'b1;
    wait_cyc(s0 + 70);  rx_raw = 1'b0;             // R7: quantum 7, -2
    wait_cyc(s0 + 88);  cfg_sjw = 2'd1;
    wait_cyc(s0 + 94);  rx_raw = 1'b1;
    wait_cyc(s0 + 102); rx_raw = 1'b0;             // R7: quantum 6, error 3 limited to 1
    wait_cyc(s0 + 110); cfg_sjw = 2'd2;
    wait_cyc(s0 + 122); rx_raw = 1'b1; tx_dom = 1'b1;
    wait_cyc(s0 + 128); rx_raw = 1'b0;             // R8: suppressed
    wait_cyc(s0 + 142); tx_dom = 1'b0;
    wait_cyc(s0 + 158); rx_raw = 1'b1;
    wait_cyc(s0 + 164); rx_raw = 1'b0;             // R9: quantum 2, +2
    wait_cyc(s0 + 168); rx_raw = 1'b1;
    wait_cyc(s0 + 172); rx_raw = 1'b0;             // R9: second edge ignored
    wait_cyc(s0 + 185);
    armed = 1'b0;
    chk("R2", "missing strobes", sbq.size(), 0);

    // quantum 1 clock, bit 6 quanta, sample at end of quantum 3
    wait_cyc(s0 + 186);
    rx_raw = 1'b1;
    cfg_brp = 6'd0; cfg_prop = 4'd1; cfg_ph1 = 4'd2; cfg_ph2 = 4'd2; cfg_sjw = 2'd1;
    wait_cyc(s0 + 200);
    hsync_en = 1'b1;
    s1 = cyc + 3;
    push(0, s1 + 4,  0, "R5");
    push(1, s1 + 6,  0, "R2");
    push(0, s1 + 10, 0, "R3");
    push(1, s1 + 12, 0, "R2");
    push(0, s1 + 16, 0, "R3");
    push(1, s1 + 18, 0, "R2");
    rx_raw = 1'b0;
    wait_cyc(s1);
    hsync_en = 1'b0;
    armed = 1'b1;
    wait_cyc(s1 + 19);
    armed = 1'b0;
    chk("R2", "missing strobes", sbq.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule